// File: doc/BRIEF.md
# Calendar Clock with Update-In-Progress Window

This block is a battery-style time-of-day and calendar counter reached through a two-address register port. A write to the even address picks one of 128 byte registers, and the odd address then reads or writes that register. Once per second, derived from a 32.768 kHz clock-enable input, the counter steps seconds, minutes, hours, weekday, day of month, month, two-digit year and century. Each field is held either as packed BCD or as plain binary, and hours run either 0 to 23 or 1 to 12 with a PM flag.

Software reads the time safely by polling an update-in-progress flag. The flag rises a few time-base ticks before each rollover. To load a new time, software sets a freeze bit, writes the fields and clears the bit. Software can also hold the prescaler in reset. When it releases the prescaler, the first rollover comes exactly half a second later, so a new time can be started on a known sub-second phase. The byte registers not used for time or control act as plain scratch storage.

Top module: `rtc_bcd_clock`

## Requirements
- R1: Writing the even address (bus_addr=0) stores bus_wdata[6:0] as the register index, ignoring bit 7. Reading the even address returns 0xFF. Read data appears on bus_rdata one clock after the read strobe.
- R2: After reset, control register A (index 10) reads 0x26 and control register B (index 11) reads 0x02. Status register C (index 12) reads 0x00 and status register D (index 13) reads 0x80. Bit 7 of register A is read-only: a write never stores it.
- R3: When the prescaler is running and B bit 7 is clear, the seconds byte (index 0) advances once every TICKS_PER_SEC enabled ticks. A seconds rollover carries into minutes (index 2), and a minutes rollover carries into hours (index 4).
- R4: With B bit 2 clear, every time field is packed BCD: 0x09 steps to 0x10, and 0x59 steps to 0x00 with a carry.
- R5: With B bit 2 set, every time field is plain binary: 59 (0x3B) steps to 0 with a carry.
- R6: With B bit 1 clear, hours run 1 to 12 in the low 7 bits, and bit 7 of the hours byte means PM. 11 AM steps to 12 PM (0x92 in BCD), 12 PM steps to 1 PM (0x81), and 11 PM steps to 12 AM (0x12) and advances the date. With B bit 1 set, hours run 0 to 23.
- R7: A day rollover advances the weekday (index 6, 1 to 7, wrapping to 1) and the day of month (index 7). The day of month wraps to 1 after 30 days in months 4, 6, 9 and 11, after 31 days in the other months, and after 29 days in month 2 when the year value is divisible by 4 (28 days otherwise). The month (index 8, 1 to 12) then advances. Month 12 wraps to 1 and advances the year (index 9, 0 to 99). Year 99 wraps to 0 and advances the century (index 50).
- R8: While B bit 7 (freeze) is set, no time field advances, and writes to the time fields are stored as given.
- R9: Register A bit 7 reads 1 during the last UIP_TICKS ticks before each rollover. It reads 0 at all other times, and also whenever the prescaler is stopped or B bit 7 is set.
- R10: While register A bits 6:5 are 11, the prescaler is held and no rollover happens. When A bits 6:4 change to a running value (000, 001 or 010), the first rollover comes TICKS_PER_SEC/2 ticks after the release write.
- R11: Writes to indices 12 and 13 have no effect. All indices other than the time fields and registers A to D (including 1, 3, 5, 14 and 127) behave as plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz time-base tick |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench releases the prescaler at a known clock edge so that every rollover lands on a cycle it can predict. It then reads the update flag inside and outside the final window, and reads the seconds byte just before and just after the half-second point. A design that started the first update a full second after release, or opened the window at the wrong place, shows the wrong byte at those exact cycles. Carry chains are driven through the end of a year, the end of 30-day months, February in leap and non-leap years, and the three awkward 12-hour crossings. A 12-hour clock that treated 12 as zero, or that lost the PM bit, would then show the wrong hour byte. The bench also checks freezing, the held prescaler, the read-only bits and the ignored writes by reading back the exact bytes those writes could have changed.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

    // register indices whose position other logic decodes
    localparam int IDX_SEC   = 0;
    localparam int IDX_MIN   = 2;
    localparam int IDX_HOUR  = 4;
    localparam int IDX_WDAY  = 6;
    localparam int IDX_MDAY  = 7;
    localparam int IDX_MON   = 8;
    localparam int IDX_YEAR  = 9;
    localparam int IDX_CTLA  = 10;
    localparam int IDX_CTLB  = 11;
    localparam int IDX_FLAGC = 12;
    localparam int IDX_STATD = 13;
    localparam int IDX_CENT  = 50;

    // control B bit positions
    localparam int B_FREEZE = 7;
    localparam int B_BIN    = 2;
    localparam int B_H24    = 1;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
        logic [7:0] cent;
    } caltime_t;

    function automatic logic [6:0] fld_dec(input logic [7:0] v, input logic bin);
        if (bin) return v[6:0];
        return 7'({3'b000, v[7:4]} * 7'd10 + {3'b000, v[3:0]});
    endfunction

    function automatic logic [7:0] fld_enc(input logic [6:0] n, input logic bin);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = n / 7'd10;
        ones = n % 7'd10;
        if (bin) return {1'b0, n};
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
        case (mon)
            7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
            default:                  return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_timebase.sv
`timescale 1ns/1ps
module rtc_timebase #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [2:0] div_sel,
    input  logic       frozen,
    output logic       sec_edge,
    output logic       uip,
    output logic       div_hold
);
    localparam int PSW = $clog2(TICKS_PER_SEC);
    localparam logic [PSW-1:0] LAST      = PSW'(TICKS_PER_SEC - 1);
    localparam logic [PSW-1:0] HALF      = PSW'(TICKS_PER_SEC / 2);
    localparam logic [PSW-1:0] UIP_START = PSW'(TICKS_PER_SEC - UIP_TICKS);

    logic [PSW-1:0] ps_d, ps_q;
    logic           div_run;

    always_comb begin
        div_hold = (div_sel[2:1] == 2'b11);
        div_run  = (div_sel <= 3'b010);
        ps_d     = ps_q;
        if (div_hold) begin
            // parked at mid-second: release gives a half-second first step
            ps_d = HALF;
        end else if (div_run && tick_en) begin
            ps_d = (ps_q == LAST) ? '0 : ps_q + 1'b1;
        end
        sec_edge = div_run && tick_en && (ps_q == LAST);
        uip      = div_run && !frozen && (ps_q >= UIP_START);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end
endmodule

// File: rtl/rtc_time_step.sv
`timescale 1ns/1ps
module rtc_time_step
    import rtc_cal_pkg::*;
(
    input  caltime_t cur,
    input  logic     bin_mode,
    input  logic     h24_mode,
    output caltime_t nxt
);
    logic [6:0] s, m, hv, h_now, h_nxt, h12, wd, md, mo, yr, ce, mlen;
    logic [7:0] h12_enc;
    logic       c_min, c_hour, c_day, c_mon, c_year, c_cent;

    always_comb begin
        s  = fld_dec(cur.sec, bin_mode);
        m  = fld_dec(cur.min, bin_mode);
        hv = fld_dec({1'b0, cur.hour[6:0]}, bin_mode);
        wd = fld_dec(cur.wday, bin_mode);
        md = fld_dec(cur.mday, bin_mode);
        mo = fld_dec(cur.mon, bin_mode);
        yr = fld_dec(cur.year, bin_mode);
        ce = fld_dec(cur.cent, bin_mode);

        // hours normalised to 0..23 regardless of the stored form
        h_now = h24_mode ? hv
                         : (((hv == 7'd12) ? 7'd0 : hv) + (cur.hour[7] ? 7'd12 : 7'd0));

        mlen   = month_days(mo, yr);
        c_min  = (s >= 7'd59);
        c_hour = c_min && (m >= 7'd59);
        c_day  = c_hour && (h_now >= 7'd23);
        c_mon  = c_day && (md >= mlen);
        c_year = c_mon && (mo >= 7'd12);
        c_cent = c_year && (yr >= 7'd99);

        h_nxt   = c_day ? 7'd0 : h_now + 7'd1;
        h12     = (h_nxt == 7'd0 || h_nxt == 7'd12) ? 7'd12
                : (h_nxt > 7'd12) ? h_nxt - 7'd12 : h_nxt;
        h12_enc = fld_enc(h12, bin_mode);

        nxt     = cur;
        nxt.sec = fld_enc(c_min ? 7'd0 : s + 7'd1, bin_mode);
        if (c_min)  nxt.min  = fld_enc(c_hour ? 7'd0 : m + 7'd1, bin_mode);
        if (c_hour) nxt.hour = h24_mode ? fld_enc(h_nxt, bin_mode)
                                        : {(h_nxt >= 7'd12), h12_enc[6:0]};
        if (c_day) begin
            nxt.wday = fld_enc((wd >= 7'd7) ? 7'd1 : wd + 7'd1, bin_mode);
            nxt.mday = fld_enc(c_mon ? 7'd1 : md + 7'd1, bin_mode);
        end
        if (c_mon)  nxt.mon  = fld_enc(c_year ? 7'd1 : mo + 7'd1, bin_mode);
        if (c_year) nxt.year = fld_enc(c_cent ? 7'd0 : yr + 7'd1, bin_mode);
        if (c_cent) nxt.cent = fld_enc((ce >= 7'd99) ? 7'd0 : ce + 7'd1, bin_mode);
    end
endmodule

// File: rtl/rtc_bcd_clock.sv
`timescale 1ns/1ps
module rtc_bcd_clock
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8,
    parameter int REG_COUNT     = 128   // at least 64: century sits at index 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       bus_en,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    localparam int IDX_W = $clog2(REG_COUNT);

    typedef struct packed {
        logic [IDX_W-1:0]           idx;
        logic [REG_COUNT-1:0][7:0]  mem;
        logic [7:0]                 rdata;
    } regs_t;

    regs_t      st_d, st_q;
    caltime_t   cur_t, nxt_t;
    logic [7:0] ctl_a, ctl_b, sec_cur;
    logic [IDX_W-1:0] idx_cur;
    logic       sec_edge, uip, div_hold, set_mode;

    function automatic regs_t reset_image();
        regs_t r;
        r = '0;
        r.mem[IDX_CTLA] = 8'h26;
        r.mem[IDX_CTLB] = 8'h02;
        r.mem[IDX_WDAY] = 8'h01;
        r.mem[IDX_MDAY] = 8'h01;
        r.mem[IDX_MON]  = 8'h01;
        return r;
    endfunction

    assign ctl_a    = st_q.mem[IDX_CTLA];
    assign ctl_b    = st_q.mem[IDX_CTLB];
    assign set_mode = ctl_b[B_FREEZE];
    assign sec_cur  = st_q.mem[IDX_SEC];
    assign idx_cur  = st_q.idx;
    assign cur_t    = {st_q.mem[IDX_SEC], st_q.mem[IDX_MIN], st_q.mem[IDX_HOUR],
                       st_q.mem[IDX_WDAY], st_q.mem[IDX_MDAY], st_q.mem[IDX_MON],
                       st_q.mem[IDX_YEAR], st_q.mem[IDX_CENT]};

    rtc_timebase #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UIP_TICKS    (UIP_TICKS)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .div_sel (ctl_a[6:4]),
        .frozen  (set_mode),
        .sec_edge(sec_edge),
        .uip     (uip),
        .div_hold(div_hold)
    );

    rtc_time_step u_step (
        .cur     (cur_t),
        .bin_mode(ctl_b[B_BIN]),
        .h24_mode(ctl_b[B_H24]),
        .nxt     (nxt_t)
    );

    always_comb begin
        st_d = st_q;

        // once-per-second step, skipped while frozen
        if (sec_edge && !set_mode) begin
            st_d.mem[IDX_SEC]  = nxt_t.sec;
            st_d.mem[IDX_MIN]  = nxt_t.min;
            st_d.mem[IDX_HOUR] = nxt_t.hour;
            st_d.mem[IDX_WDAY] = nxt_t.wday;
            st_d.mem[IDX_MDAY] = nxt_t.mday;
            st_d.mem[IDX_MON]  = nxt_t.mon;
            st_d.mem[IDX_YEAR] = nxt_t.year;
            st_d.mem[IDX_CENT] = nxt_t.cent;
        end

        // host write wins over the step for the same byte
        if (bus_en && bus_we) begin
            if (!bus_addr) begin
                st_d.idx = bus_wdata[IDX_W-1:0];
            end else if (st_q.idx == IDX_W'(IDX_CTLA)) begin
                st_d.mem[IDX_CTLA] = {1'b0, bus_wdata[6:0]};
            end else if (st_q.idx != IDX_W'(IDX_FLAGC) && st_q.idx != IDX_W'(IDX_STATD)) begin
                st_d.mem[st_q.idx] = bus_wdata;
            end
        end

        if (bus_en && !bus_we) begin
            if (!bus_addr)                             st_d.rdata = 8'hFF;
            else if (st_q.idx == IDX_W'(IDX_CTLA))     st_d.rdata = {uip, ctl_a[6:0]};
            else if (st_q.idx == IDX_W'(IDX_FLAGC))    st_d.rdata = 8'h00;
            else if (st_q.idx == IDX_W'(IDX_STATD))    st_d.rdata = 8'h80;
            else                                       st_d.rdata = st_q.mem[st_q.idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_image();
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/rtc_bcd_clock_chk.sv
`timescale 1ns/1ps
module rtc_bcd_clock_chk #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic             bus_addr,
    input logic [7:0]       bus_rdata,
    input logic [IDX_W-1:0] idx_cur,
    input logic [7:0]       sec_cur,
    input logic             set_mode,
    input logic             sec_edge,
    input logic             uip,
    input logic             div_hold
);
    logic data_wr;
    assign data_wr = bus_en && bus_we && bus_addr;

    assert_index_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !bus_addr) |=> (bus_rdata == 8'hFF));

    assert_flagc_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr && idx_cur == IDX_W'(rtc_cal_pkg::IDX_FLAGC))
        |=> (bus_rdata == 8'h00));

    assert_sec_only_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_edge && !data_wr) |=> $stable(sec_cur));

    assert_freeze_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && !data_wr) |=> $stable(sec_cur));

    assert_uip_precedes_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_edge && !set_mode) |-> uip);

    assert_hold_no_uip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_hold |-> (!uip && !sec_edge));
endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/rtc_bcd_clock_bench.sv
`timescale 1ns/1ps
module rtc_bcd_clock_bench;
    localparam int TPS  = 64;
    localparam int UIPT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int rel = 0;
    int last_edge = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];
    logic  rd_pend = 1'b0;

    rtc_bcd_clock #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) u_rtc_bcd_clock (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rd_pend <= bus_en && !bus_we;
    end

    // monitor: compares each registered read against the queued expectation
    always @(negedge clk) begin
        item_t it;
        if (rd_pend) begin
            n_vec++;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read: got %02h expected none", bus_rdata);
            end else begin
                it = sbq.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %02h expected %02h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    function automatic int fidx(input int f);
        case (f)
            0: return 0;  1: return 2;  2: return 4;  3: return 6;
            4: return 7;  5: return 8;  6: return 9;  default: return 50;
        endcase
    endfunction

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        last_edge = cyc;
    endtask

    task automatic wreg(input int idx, input logic [7:0] d);
        wr(1'b0, 8'(idx));
        wr(1'b1, d);
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        sbq.push_back('{exp, tag});
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic rd_now(input int idx, input logic [7:0] exp, input string tag);
        wr(1'b0, 8'(idx));
        rd(1'b1, exp, tag);
    endtask

    // read register idx with the data read captured at edge rel+k
    task automatic rd_at(input int idx, input int k, input logic [7:0] exp, input string tag);
        if (cyc > rel + k - 2) begin
            n_vec++; n_bad++;
            $display("FAIL %s: schedule slipped, got cycle %0d expected %0d", tag, cyc, rel + k - 2);
        end
        while (cyc < rel + k - 2) @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 8'(idx);
        @(negedge clk);
        sbq.push_back('{exp, tag});
        bus_we = 1'b0; bus_addr = 1'b1;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    // freeze, hold prescaler, load fields, set mode, release prescaler
    task automatic load(input logic [7:0] mode, input logic stay_set, input logic [63:0] t);
        wreg(11, 8'h80 | mode);
        wreg(10, 8'h66);
        for (int f = 0; f < 8; f++) wreg(fidx(f), t[63-8*f -: 8]);
        wreg(11, stay_set ? (8'h80 | mode) : mode);
        wreg(10, 8'h26);
        rel = last_edge;
    endtask

    task automatic run_case(input logic [7:0] mode, input logic [63:0] tin,
                            input logic [63:0] texp, input string tag);
        load(mode, 1'b0, tin);
        rd_at(10, 10, 8'h26, {tag, " R9 flag low mid-second"});
        rd_at(10, 28, 8'hA6, {tag, " R9 flag high before step"});
        rd_at(0, 31, tin[63:56], {tag, " R10 no step before half second"});
        for (int f = 0; f < 8; f++)
            rd_at(fidx(f), 34 + 2*f, texp[63-8*f -: 8], {tag, " field"});
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state and index port
        rd(1'b0, 8'hFF, "R1 index port read");
        rd_now(10, 8'h26, "R2 reset A");
        rd_now(11, 8'h02, "R2 reset B");
        rd_now(12, 8'h00, "R2 reset C");
        rd_now(13, 8'h80, "R2 reset D");

        // R7 R4 full rollover in BCD 24h
        run_case(8'h02, 64'h59_59_23_07_31_12_99_19, 64'h00_00_00_01_01_01_00_20, "R7 R4 year end");
        // R4 R3 decimal digit carry only
        run_case(8'h02, 64'h09_34_12_03_15_06_21_20, 64'h10_34_12_03_15_06_21_20, "R4 R3 digit carry");
        // R3 seconds into minutes
        run_case(8'h02, 64'h59_07_05_03_15_06_21_20, 64'h00_08_05_03_15_06_21_20, "R3 minute carry");
        // R7 leap February
        run_case(8'h02, 64'h59_59_23_04_28_02_24_20, 64'h00_00_00_05_29_02_24_20, "R7 leap feb");
        // R7 non-leap February
        run_case(8'h02, 64'h59_59_23_04_28_02_23_20, 64'h00_00_00_05_01_03_23_20, "R7 plain feb");
        // R7 thirty-day month
        run_case(8'h02, 64'h59_59_23_06_30_04_21_20, 64'h00_00_00_07_01_05_21_20, "R7 april end");
        // R5 binary
        run_case(8'h06, 64'h3B_3B_17_02_1C_02_17_14, 64'h00_00_00_03_01_03_17_14, "R5 binary feb");
        // R6 twelve-hour crossings
        run_case(8'h00, 64'h59_59_11_03_10_05_21_20, 64'h00_00_92_03_10_05_21_20, "R6 11am to 12pm");
        run_case(8'h00, 64'h59_59_91_03_10_05_21_20, 64'h00_00_12_04_11_05_21_20, "R6 11pm to 12am");
        run_case(8'h00, 64'h59_59_92_03_10_05_21_20, 64'h00_00_81_03_10_05_21_20, "R6 12pm to 1pm");

        // R8 freeze
        load(8'h02, 1'b1, 64'h05_10_10_03_10_05_21_20);
        rd_at(10, 28, 8'h26, "R9 flag low while frozen");
        rd_at(0, 40, 8'h05, "R8 frozen after half second");
        rd_at(0, 100, 8'h05, "R8 frozen after full second");
        wreg(0, 8'h33);
        rd_now(0, 8'h33, "R8 write while frozen");

        // R10 held prescaler
        wreg(10, 8'h66);
        wreg(11, 8'h02);
        wreg(0, 8'h10);
        repeat (150) @(negedge clk);
        rd_now(0, 8'h10, "R10 no step while held");
        rd_now(10, 8'h66, "R10 flag low while held");

        // R1 R11 R2 storage, ignored writes and read-only bit
        wr(1'b0, 8'h8E);
        wr(1'b1, 8'h77);
        rd_now(14, 8'h77, "R1 index bit7 ignored");
        wreg(20, 8'h5A);
        wreg(127, 8'hC3);
        wreg(1, 8'h45);
        rd_now(20, 8'h5A, "R11 scratch 20");
        rd_now(127, 8'hC3, "R11 scratch 127");
        rd_now(1, 8'h45, "R11 scratch 1");
        wreg(12, 8'hFF);
        rd_now(12, 8'h00, "R11 write C ignored");
        wreg(13, 8'h00);
        rd_now(13, 8'h80, "R11 write D ignored");
        wreg(10, 8'hE6);
        rd_now(10, 8'h66, "R2 A bit7 read-only");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule